// File: doc/BRIEF.md
# Oscillator-Halting Standby Controller

This controller sits beside a small processor core and manages its deepest sleep state. When the core asks to sleep while it runs on the main clock, the controller turns off the main oscillator's enable and keeps the core stalled. It then watches for three events that end the sleep: a request on the external reset line, an interrupt request that is not masked, and a test event that is not masked.

When one of these events arrives, the controller turns the oscillator back on. It then counts a settling interval before it lets the core run. For interrupt and test wakes, a small select input sets the length of that interval. A reset wake always uses a fixed long interval. At the end of the interval the controller shows a code for one cycle. The code tells the core whether to continue with its next instruction, to take a vectored interrupt, or to carry out reset processing. The interrupt outcome depends on four flags: mask, priority, global enable and in-service priority. All of these flags are captured at the moment of the wake.

If an unmasked interrupt is already pending when sleep is requested, the oscillator is never switched off. The controller goes straight to the settling wait, much like a light halt.

Top module: `stop_mode_ctrl`

## Requirements
- R1: A sleep request (`stop_req`) is honoured only in the run state while `on_main_clk` is 1. A request made with `on_main_clk` at 0, or made while the controller is not in the run state, leaves `osc_en` and `cpu_stall` unchanged.
- R2: In the sleep state, `osc_en` is 0 and `cpu_stall` is 1. This is visible on the cycle after the accepted request.
- R3: An interrupt or test wake sets `osc_en` to 1. `done_valid` then rises on cycle N+1, counting the wake edge as cycle 1, where N = 2^(MIN_LOG + `stab_sel`). During cycles 1 to N, `cpu_stall` is 1 and `osc_en` is 1.
- R4: A reset wake waits 2^RST_LOG cycles. Counting starts from the first edge at which `ext_reset` is low. If `ext_reset` is high for H edges, `done_valid` rises on cycle 2^RST_LOG + H, counting the first high edge as cycle 1.
- R5: If an unmasked interrupt is pending when an accepted sleep request arrives, `osc_en` stays 1 throughout. The controller enters the settling wait at once, with the timing of R3 and the outcome of R6 and R7.
- R6: An interrupt request with `int_mask`=1 is ignored, and sleep is held. With `int_mask`=0 and `int_en`=0, the outcome is code 00.
- R7: With `int_mask`=0 and `int_en`=1, the outcome depends on `int_lowpri`. If `int_lowpri` is 0, the code is 01. If `int_lowpri` is 1, the code is 01 when `isp_flag` is 1, and 00 when `isp_flag` is 0.
- R8: A test wake with `test_mask`=0 gives code 00 after the interval. With `test_mask`=1 it is ignored, and sleep is held.
- R9: `ext_reset` wins over every other source, in every state. That includes an interval already being counted. It restarts the wait with the reset length and gives code 10.
- R10: `done_valid` is high for exactly one cycle, during which `cpu_stall` is still 1. On the next cycle `cpu_stall` is 0. When `done_valid` is 0, `done_code` is 00. The codes are 00 for the next instruction, 01 for interrupt service and 10 for reset processing.
- R11: The flags and `stab_sel` are captured at the wake edge. Changing them afterwards does not change the interval or the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control and count clock |
| rst_n | input | 1 | Active-low asynchronous power-on clear |
| stop_req | input | 1 | Sleep request from the core |
| on_main_clk | input | 1 | 1 when the core runs from the main clock |
| int_req | input | 1 | Interrupt request |
| int_mask | input | 1 | 1 masks the interrupt request |
| int_lowpri | input | 1 | 1 marks the request as low priority |
| int_en | input | 1 | Global interrupt enable |
| isp_flag | input | 1 | In-service priority flag |
| test_req | input | 1 | Test event |
| test_mask | input | 1 | 1 masks the test event |
| ext_reset | input | 1 | Reset wake, active high |
| stab_sel | input | SEL_W | Settling-interval select |
| osc_en | output | 1 | Main oscillator enable |
| cpu_stall | output | 1 | Holds the core |
| done_valid | output | 1 | One-cycle outcome strobe |
| done_code | output | 2 | Outcome: 00 next, 01 interrupt, 10 reset |

## Verification
A corrupted state register shows up at once at the ports. If the controller wrongly leaves sleep, `osc_en` rises. If it wrongly stays in the wait, `done_valid` never appears. An error in the counter or in the captured interval length moves the `done_valid` edge by at least one cycle, and that edge is measured exactly. A wrong captured flag changes `done_code` in the single strobe cycle, so every flag combination is swept against every interval.

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl #(
  parameter int SEL_W   = 3,
  parameter int MIN_LOG = 8,
  parameter int RST_LOG = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             on_main_clk,
  input  logic             int_req,
  input  logic             int_mask,
  input  logic             int_lowpri,
  input  logic             int_en,
  input  logic             isp_flag,
  input  logic             test_req,
  input  logic             test_mask,
  input  logic             ext_reset,
  input  logic [SEL_W-1:0] stab_sel,
  output logic             osc_en,
  output logic             cpu_stall,
  output logic             done_valid,
  output logic [1:0]       done_code
);

  localparam int SEL_MAX = MIN_LOG + (1 << SEL_W) - 1;
  localparam int MAX_LOG = (SEL_MAX > RST_LOG) ? SEL_MAX : RST_LOG;
  localparam int CNT_W   = MAX_LOG + 1;
  localparam int LOG_W   = $clog2(MAX_LOG + 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_STAB, S_RESUME} mode_t;

  mode_t            state;
  logic [CNT_W-1:0] cnt;
  logic [LOG_W-1:0] wait_log;
  logic [1:0]       code;

  wire              int_wake = int_req & ~int_mask;
  wire              tst_wake = test_req & ~test_mask;
  wire [1:0]        int_code = (int_en & (~int_lowpri | isp_flag)) ? 2'b01 : 2'b00;
  wire [LOG_W-1:0]  sel_log  = LOG_W'(MIN_LOG) + LOG_W'(stab_sel);
  wire [CNT_W-1:0]  limit    = (CNT_W'(1) << wait_log) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RUN;
      cnt      <= '0;
      wait_log <= '0;
      code     <= 2'b00;
    end else if (ext_reset) begin
      state    <= S_STAB;
      cnt      <= '0;
      wait_log <= LOG_W'(RST_LOG);
      code     <= 2'b10;
    end else begin
      case (state)
        S_RUN:
          if (stop_req && on_main_clk) begin
            if (int_wake) begin
              state    <= S_STAB;
              cnt      <= '0;
              wait_log <= sel_log;
              code     <= int_code;
            end else begin
              state <= S_STOP;
            end
          end
        S_STOP:
          if (int_wake) begin
            state    <= S_STAB;
            cnt      <= '0;
            wait_log <= sel_log;
            code     <= int_code;
          end else if (tst_wake) begin
            state    <= S_STAB;
            cnt      <= '0;
            wait_log <= sel_log;
            code     <= 2'b00;
          end
        S_STAB:
          if (cnt == limit) state <= S_RESUME;
          else              cnt   <= cnt + CNT_W'(1);
        default:
          state <= S_RUN;
      endcase
    end
  end

  assign osc_en     = (state != S_STOP);
  assign cpu_stall  = (state != S_RUN);
  assign done_valid = (state == S_RESUME);
  assign done_code  = done_valid ? code : 2'b00;

  p_sub_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && stop_req && !on_main_clk && !ext_reset) |=> (osc_en && !cpu_stall));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && !ext_reset && !int_wake && !tst_wake) |=> (!osc_en && !done_valid));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAB) |-> (cnt <= limit));

  p_osc_into_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (state == S_STAB && cpu_stall));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid));

  p_reset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset |=> (osc_en && cpu_stall && cnt == '0 && !done_valid));

endmodule

// File: tb/test_stop_mode_ctrl.sv
module test_stop_mode_ctrl;
  localparam int SEL_W = 2, MIN_LOG = 1, RST_LOG = 5;
  localparam int RST_N = 1 << RST_LOG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, on_main_clk = 1, int_req = 0, int_mask = 0, int_lowpri = 0;
  logic int_en = 0, isp_flag = 0, test_req = 0, test_mask = 0, ext_reset = 0;
  logic [SEL_W-1:0] stab_sel = '0;
  logic osc_en, cpu_stall, done_valid;
  logic [1:0] done_code;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  stop_mode_ctrl #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .RST_LOG(RST_LOG)) i_stop_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .on_main_clk(on_main_clk),
    .int_req(int_req), .int_mask(int_mask), .int_lowpri(int_lowpri), .int_en(int_en),
    .isp_flag(isp_flag), .test_req(test_req), .test_mask(test_mask), .ext_reset(ext_reset),
    .stab_sel(stab_sel), .osc_en(osc_en), .cpu_stall(cpu_stall),
    .done_valid(done_valid), .done_code(done_code));

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic enter_stop();
    stop_req = 1; on_main_clk = 1; int_req = 0; test_req = 0;
    tick();
    stop_req = 0;
    check("R2 osc_en in sleep", osc_en, 0);
    check("R2 cpu_stall in sleep", cpu_stall, 1);
  endtask

  // Inputs are already set; the next edge is the wake edge (cycle 1).
  task automatic wait_done(input string req, input int exp_n, input int exp_code, input int hold);
    int k = 0;
    bit side_bad = 0;
    for (int i = 0; i < 400; i++) begin
      tick(); k++;
      if (k >= hold) ext_reset = 0;
      if (k == 1) begin
        stop_req = 0; int_req = 0; test_req = 0;
        int_mask = ~int_mask; int_lowpri = ~int_lowpri; int_en = ~int_en;
        isp_flag = ~isp_flag; stab_sel = ~stab_sel;
      end
      if (done_valid) break;
      if (!osc_en || !cpu_stall || done_code != 2'b00) side_bad = 1;
    end
    check({req, " R3/R4 strobe cycle"}, k, exp_n);
    check({req, " R10 outcome code"}, done_code, exp_code);
    check({req, " R3 stall/osc during wait"}, side_bad, 0);
    check({req, " R10 strobe while stalled"}, cpu_stall, 1);
    tick();
    check({req, " R10 single strobe"}, done_valid, 0);
    check({req, " R10 run after strobe"}, cpu_stall, 0);
  endtask

  task automatic held_then_reset(input string req);
    bit moved = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (osc_en || done_valid || !cpu_stall) moved = 1;
    end
    check({req, " held in sleep"}, moved, 0);
    int_req = 0; test_req = 0;
    ext_reset = 1;
    wait_done("R9 reset recovery", RST_N + 1, 2, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    tick();
    check("R10 reset state done_valid", done_valid, 0);
    check("R10 reset state cpu_stall", cpu_stall, 0);
    check("R2 reset state osc_en", osc_en, 1);

    // R1: request on subsystem clock ignored
    on_main_clk = 0; stop_req = 1;
    tick(); tick();
    stop_req = 0; on_main_clk = 1;
    check("R1 sub-clock request osc_en", osc_en, 1);
    check("R1 sub-clock request stall", cpu_stall, 0);

    // R1: request while sleeping changes nothing
    enter_stop();
    stop_req = 1; tick(); tick(); stop_req = 0;
    check("R1 request in sleep osc_en", osc_en, 0);
    int_mask = 0; int_en = 0; int_req = 1; stab_sel = 0;
    wait_done("R6 plain wake", 3, 0, 1);

    // R6 R7 R11: interrupt wake, all flags x all selects
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 16; f++) begin
        enter_stop();
        int_mask = f[3]; int_lowpri = f[2]; int_en = f[1]; isp_flag = f[0];
        stab_sel = SEL_W'(s); int_req = 1;
        if (f[3]) held_then_reset("R6 masked interrupt");
        else wait_done("R7 interrupt wake", (1 << (MIN_LOG + s)) + 1,
                       (f[1] && (!f[2] || f[0])) ? 1 : 0, 1);
      end

    // R8: test wake
    for (int s = 0; s < 4; s++) begin
      enter_stop();
      stab_sel = SEL_W'(s); test_mask = 0; test_req = 1; int_mask = 1;
      wait_done("R8 test wake", (1 << (MIN_LOG + s)) + 1, 0, 1);
      enter_stop();
      test_mask = 1; test_req = 1;
      held_then_reset("R8 masked test");
      test_mask = 0;
    end

    // R5: unmasked interrupt pending at the request
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 8; f++) begin
        int_mask = 0; int_lowpri = f[2]; int_en = f[1]; isp_flag = f[0];
        stab_sel = SEL_W'(s); int_req = 1; on_main_clk = 1; stop_req = 1;
        wait_done("R5 pending at entry", (1 << (MIN_LOG + s)) + 1,
                  (f[1] && (!f[2] || f[0])) ? 1 : 0, 1);
      end

    // R9: reset together with other wakes
    enter_stop();
    int_mask = 0; int_en = 1; int_lowpri = 0; int_req = 1;
    test_mask = 0; test_req = 1; ext_reset = 1;
    wait_done("R9 reset beats interrupt", RST_N + 1, 2, 1);

    // R9: reset during an interrupt interval
    enter_stop();
    int_mask = 0; int_en = 1; int_lowpri = 0; stab_sel = 2'd3; int_req = 1;
    tick(); int_req = 0; tick(); tick();
    ext_reset = 1;
    wait_done("R9 reset mid-wait", RST_N + 1, 2, 1);

    // R4: reset held for several edges
    for (int h = 2; h <= 5; h++) begin
      enter_stop();
      ext_reset = 1;
      wait_done("R4 held reset", RST_N + h, 2, h);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule